// File: doc/BRIEF.md
# Broadcast-Reference Motion Distortion Line Array

This block finds the best motion vector for one reference block by full search, using a row of 2*HALF+1 processing elements that work in parallel across candidate displacements, not across pixels. Each cycle the caller streams one pixel of the reference block. It also supplies, for every element, the search-window pixel that element needs for its own horizontal displacement. The reference pixel is shared by all elements. Each element adds the absolute difference to its own distortion accumulator.

After all BLK*BLK pixels of a line have been streamed, the accumulated distortions are shifted one step per cycle toward element 0. The value leaving element 0 enters a compare stage that tracks the smallest distortion and its vector. The emptying accumulators fill with zero, so the next line can start as soon as the shift-out ends. After 2*HALF+1 lines, one for each vertical displacement, a done pulse marks the final vector. Search-window storage and address generation belong to the caller.

Top module: `sad_line_array`

## Requirements
- R1: After reset, `done` and `draining` are 0, and `best_sad`, `best_m` and `best_n` are 0.
- R2: While not draining, each cycle with `in_valid` high adds |`ref_pix` - s_k| to accumulator k. Here s_k is `srch_pix[k*PIXW +: PIXW]`, and element k stands for horizontal displacement n = k - HALF. The accumulator is wide enough for BLK*BLK full-scale differences without wrapping.
- R3: A valid cycle with `first_pix` high loads every accumulator with that cycle's difference and discards what came before, even in the middle of a line.
- R4: When a valid pixel with `last_pix` high is accepted, `draining` goes high the next cycle and stays high for exactly 2*HALF+1 cycles.
- R5: While `draining` is high, `in_valid`, `first_pix`, `last_pix` and the pixel inputs have no effect.
- R6: The shift-out leaves every accumulator at zero. A line streamed without any `first_pix` therefore gives the same distortions as one that starts with it.
- R7: The compare stage replaces its stored distortion and vector only when a strictly smaller value arrives. Among equal distortions, the first one in scan order wins: line index ascending, then n ascending within a line.
- R8: Line j of a search has vertical displacement m = j - HALF. In the cycle where the shift-out of the last line ends, `done` is high for one cycle and `best_sad`, `best_m` and `best_n` hold the result. The first candidate of the next search restarts the minimum.
- R9: `done` stays low at the end of every line except the last line of a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Pixel inputs are valid this cycle |
| first_pix | input | 1 | Load accumulators instead of adding |
| last_pix | input | 1 | Last pixel of the current line |
| ref_pix | input | PIXW | Reference-block pixel, shared by all elements |
| srch_pix | input | (2*HALF+1)*PIXW | One search pixel per element, element k in bits k*PIXW and up |
| draining | output | 1 | Shift-out in progress, inputs ignored |
| done | output | 1 | One-cycle pulse, final vector valid |
| best_sad | output | PIXW+clog2(BLK*BLK) | Smallest distortion found |
| best_m | output | clog2(2*HALF+1)+1 | Vertical displacement of the best vector, signed |
| best_n | output | clog2(2*HALF+1)+1 | Horizontal displacement of the best vector, signed |

## Verification
The bench targets ties. With every candidate equal, a compare that used less-or-equal would report the last vector instead of (-HALF,-HALF). It runs a full-scale search in which every difference is maximal, which exposes a narrow accumulator. It also runs a search right after a zero-distortion one, where a minimum that did not restart would stick at zero. Junk pixels are driven during shift-out and before a mid-line `first_pix`, and one run streams lines with no `first_pix` at all. These catch an array that accepts input while draining, ignores the load flag, or leaves stale sums behind.

// File: rtl/sad_line_array.sv
module sad_line_array #(
  parameter int PIXW = 8,
  parameter int BLK  = 4,
  parameter int HALF = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic                              first_pix,
  input  logic                              last_pix,
  input  logic [PIXW-1:0]                   ref_pix,
  input  logic [(2*HALF+1)*PIXW-1:0]        srch_pix,
  output logic                              draining,
  output logic                              done,
  output logic [PIXW+$clog2(BLK*BLK)-1:0]   best_sad,
  output logic signed [$clog2(2*HALF+1):0]  best_m,
  output logic signed [$clog2(2*HALF+1):0]  best_n
);
  localparam int L  = 2*HALF+1;
  localparam int DW = PIXW + $clog2(BLK*BLK);
  localparam int CW = $clog2(L);
  localparam int IW = CW + 1;
  localparam logic [CW-1:0] LAST = CW'(L-1);
  localparam logic signed [IW-1:0] HOFF = IW'(HALF);

  logic [DW-1:0] acc [L];
  logic [DW-1:0] ad  [L];
  logic [CW-1:0] cnt, line;
  logic          take;

  for (genvar k = 0; k < L; k++) begin : g_pe
    logic [PIXW-1:0] s;
    assign s     = srch_pix[k*PIXW +: PIXW];
    assign ad[k] = DW'((ref_pix > s) ? (ref_pix - s) : (s - ref_pix));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < L; k++) acc[k] <= '0;
    end else if (draining) begin
      for (int k = 0; k < L-1; k++) acc[k] <= acc[k+1];
      acc[L-1] <= '0;
    end else if (in_valid) begin
      for (int k = 0; k < L; k++) acc[k] <= (first_pix ? '0 : acc[k]) + ad[k];
    end
  end

  assign take = (line == '0 && cnt == '0) || (acc[0] < best_sad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draining <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      line     <= '0;
      best_sad <= '0;
      best_m   <= '0;
      best_n   <= '0;
    end else begin
      done <= 1'b0;
      if (!draining) begin
        cnt <= '0;
        if (in_valid && last_pix) draining <= 1'b1;
      end else begin
        if (take) begin
          best_sad <= acc[0];
          best_m   <= $signed({1'b0, line}) - HOFF;
          best_n   <= $signed({1'b0, cnt}) - HOFF;
        end
        if (cnt == LAST) begin
          draining <= 1'b0;
          cnt      <= '0;
          done     <= (line == LAST);
          line     <= (line == LAST) ? '0 : line + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sad_line_array_chk.sv
module sad_line_array_chk #(
  parameter int HALF = 2,
  parameter int DW   = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          last_pix,
  input logic          draining,
  input logic          done,
  input logic [DW-1:0] best_sad
);
  localparam int L = 2*HALF+1;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= draining ? run + 1'b1 : '0;
  end

  p_drain_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(draining) |-> run == 16'(L));

  p_drain_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(draining) |-> $past(in_valid && last_pix));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(draining) && !draining));

  p_best_nonincr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && $past(draining) && $past(draining, 2)) |-> best_sad <= $past(best_sad));
endmodule

bind sad_line_array sad_line_array_chk #(.HALF(HALF), .DW(PIXW + $clog2(BLK*BLK))) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .last_pix(last_pix),
  .draining(draining), .done(done), .best_sad(best_sad)
);

// File: tb/sim_sad_line_array.sv
`timescale 1ns/1ps
module sim_sad_line_array;
  localparam int PIXW = 8, BLK = 4, HALF = 2;
  localparam int L = 2*HALF+1, PIXN = BLK*BLK;
  localparam int DW = PIXW + $clog2(PIXN), IW = $clog2(L) + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, first_pix, last_pix, draining, done;
  logic [PIXW-1:0] ref_pix;
  logic [L*PIXW-1:0] srch_pix;
  logic [DW-1:0] best_sad;
  logic signed [IW-1:0] best_m, best_n;

  int n_run = 0, n_fail = 0;

  sad_line_array #(.PIXW(PIXW), .BLK(BLK), .HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_pix(first_pix),
    .last_pix(last_pix), .ref_pix(ref_pix), .srch_pix(srch_pix),
    .draining(draining), .done(done), .best_sad(best_sad),
    .best_m(best_m), .best_n(best_n));

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_junk(bit first);
    in_valid  = 1'b1;
    first_pix = first;
    last_pix  = 1'b0;
    ref_pix   = PIXW'($urandom_range(255));
    for (int n = 0; n < L; n++) srch_pix[n*PIXW +: PIXW] = PIXW'($urandom_range(255));
  endtask

  // modes: 0 random, 1 all equal, 2 full scale, 3 planted, 4 mid-line restart, 5 no first flag, 6 junk while draining
  task automatic run_search(int mode);
    int rb[PIXN];
    int es[L][L];
    int s, d, cnt, bs, bm, bn;
    string tag;
    for (int p = 0; p < PIXN; p++)
      rb[p] = (mode == 1) ? 77 : (mode == 2) ? 255 : (mode == 3) ? 100 + $urandom_range(55) : $urandom_range(255);
    for (int m = 0; m < L; m++) begin
      for (int n = 0; n < L; n++) es[m][n] = 0;
      if (mode == 4) begin
        for (int p = 0; p < 5; p++) begin
          @(negedge clk);
          drive_junk(p == 0);
        end
      end
      for (int p = 0; p < PIXN; p++) begin
        @(negedge clk);
        in_valid  = 1'b1;
        first_pix = (mode == 5) ? 1'b0 : (p == 0);
        last_pix  = (p == PIXN-1);
        ref_pix   = PIXW'(rb[p]);
        for (int n = 0; n < L; n++) begin
          if (mode == 1) s = 77;
          else if (mode == 2) s = 0;
          else if (mode == 3) s = (m == L-1 && n == L-1) ? rb[p] : 100 + $urandom_range(55);
          else s = $urandom_range(255);
          srch_pix[n*PIXW +: PIXW] = PIXW'(s);
          d = rb[p] - s;
          if (d < 0) d = -d;
          es[m][n] += d;
        end
      end
      @(negedge clk);
      in_valid = 1'b0; first_pix = 1'b0; last_pix = 1'b0;
      cnt = 0;
      while (draining) begin
        cnt++;
        if (mode == 6) begin
          drive_junk(1'($urandom_range(1)));
          last_pix = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0; first_pix = 1'b0; last_pix = 1'b0;
      end
      check("R4 drain length", cnt, L);
      if (m < L-1) check("R9 done low between lines", int'(done), 0);
    end
    bs = es[0][0]; bm = 0; bn = 0;
    for (int m = 0; m < L; m++)
      for (int n = 0; n < L; n++)
        if (es[m][n] < bs) begin bs = es[m][n]; bm = m; bn = n; end
    tag = (mode == 2) ? "R2 R8 full scale after restart" : (mode == 4) ? "R3 mid-line load" :
          (mode == 5) ? "R6 cleared accumulators" : (mode == 6) ? "R5 input ignored" : "R7 minimum";
    check("R8 done pulse", int'(done), 1);
    check(tag, int'(best_sad), bs);
    check({tag, " m"}, int'(best_m), bm - HALF);
    check({tag, " n"}, int'(best_n), bn - HALF);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; first_pix = 1'b0; last_pix = 1'b0;
    ref_pix = '0; srch_pix = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 draining", int'(draining), 0);
    check("R1 best_sad", int'(best_sad), 0);
    check("R1 best_m", int'(best_m), 0);
    check("R1 best_n", int'(best_n), 0);
    run_search(0);
    run_search(1);
    run_search(2);
    run_search(3);
    run_search(4);
    run_search(5);
    run_search(6);
    for (int i = 0; i < 6; i++) run_search(0);
    run_search(1);
    run_search(3);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule